// File: doc/BRIEF.md
# Single-Bit Operation Unit

This unit runs the single-bit instructions of a 4-bit controller whose data memory holds one nibble per address. A caller presents an operation, an addressing mode, an 8-bit operand field, a 2-bit bit field and the current H and L register values. The unit works out an 8-bit nibble address and a bit index. It reads that nibble through a synchronous memory port, then performs one of three actions:
- write the nibble back with exactly one bit changed,
- test the bit and raise a skip request, or
- fold the bit into the carry flag it holds.

Each accepted instruction takes two cycles after the start cycle. The first cycle issues the read. The second cycle pulses `done` and carries the skip, error and write signals. Fetch, program-counter handling and whatever sits behind the memory addresses belong to the surrounding core.

Top module: `bitop_unit`

## Requirements
- R1: After reset, `done`, `skip`, `err`, `busy`, `mem_rd`, `mem_wr` and `cy` are all 0.
- R2: `start` is sampled while the unit is idle, at clock edge T. From edge T, `mem_rd` is high for one cycle, with `mem_addr` valid. From edge T+1, `done` is high for exactly one cycle, and `skip`, `err` and `mem_wr` are valid in that same cycle. Memory read data must arrive one cycle after `mem_rd`.
- R3: The address is formed from `mode`:
  - mode 0 (direct): the address is `opnd` and the bit is `bsel`.
  - mode 1 (special region): the address is {2'b11, `opnd[5:0]`} and the bit is `bsel`.
  - mode 2 (L-indirect): the address is {`opnd[7:2]`, `l_reg[3:2]`} and the bit is `l_reg[1:0]`.
  - mode 3 (H-based): the address is {`h_reg`, `opnd[3:0]`} and the bit is `bsel`.
- R4: Operation 0 (set) and operation 1 (clear) write the read nibble back with the selected bit forced to 1 or 0. The other three bits are unchanged.
- R5: Operation 2 raises `skip` when the bit is 1. Operation 3 raises `skip` when the bit is 0. Neither operation writes.
- R6: Operation 4 (test-and-clear) raises `skip` and writes the nibble back with the bit cleared only when the bit was 1. When the bit was 0, it neither skips nor writes.
- R7: Operations 5, 6 and 7 set `cy` to `cy` AND, OR and XOR the bit respectively. The new value is visible from the cycle after `done`. These operations never skip or write.
- R8: `cy` changes only on completion of a legal operation in the range 5 to 7.
- R9: Operations 4 to 7 in mode 0 are illegal. An illegal operation raises `err` with `done`, does not skip, does not write, and leaves `cy` unchanged.
- R10: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (sampled while idle) |
| op | input | 3 | Operation code |
| mode | input | 2 | Addressing mode |
| opnd | input | 8 | Operand address field |
| bsel | input | 2 | Bit index field |
| h_reg | input | 4 | H register value |
| l_reg | input | 4 | L register value |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| skip | output | 1 | Skip request, valid with done |
| err | output | 1 | Illegal pairing, valid with done |
| cy | output | 1 | Carry flag |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 8 | Nibble address |
| mem_wdata | output | 4 | Write data |
| mem_rdata | input | 4 | Read data, one cycle after mem_rd |

## Verification
The bench targets the following corner cases:
- **L-indirect mode, all four bit indices.** A design that took the bit from the wrong part of L, or that mixed up its upper bits, would touch the wrong nibble or the wrong bit.
- **Test-and-clear on a bit that is 0.** A design that wrote unconditionally would show up through the memory model.
- **Combine operations in direct mode.** A design that did not flag these would change the carry.
- **Set and clear on nibbles with mixed neighbouring bits.** A design that disturbed the other bits would be exposed.
- **A second start while busy.** A design that accepted it would produce an extra done pulse.

// File: rtl/bitop_unit.sv
module bitop_unit #(
  parameter logic [1:0] SPECIAL_TOP = 2'b11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] op,
  input  logic [1:0] mode,
  input  logic [7:0] opnd,
  input  logic [1:0] bsel,
  input  logic [3:0] h_reg,
  input  logic [3:0] l_reg,
  output logic       busy,
  output logic       done,
  output logic       skip,
  output logic       err,
  output logic       cy,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic [7:0] mem_addr,
  output logic [3:0] mem_wdata,
  input  logic [3:0] mem_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_EX} st_t;
  localparam logic [2:0] OP_SET = 3'd0, OP_CLR = 3'd1, OP_SKT = 3'd2, OP_SKF = 3'd3,
                         OP_TCLR = 3'd4, OP_AND = 3'd5, OP_OR = 3'd6, OP_XOR = 3'd7;

  st_t        st;
  logic [2:0] op_q;
  logic       ill_q;
  logic [7:0] addr_q;
  logic [1:0] bit_q;
  logic [7:0] addr_d;
  logic [1:0] bit_d;

  always_comb begin
    bit_d = bsel;
    case (mode)
      2'd0: addr_d = opnd;
      2'd1: addr_d = {SPECIAL_TOP, opnd[5:0]};
      2'd2: begin addr_d = {opnd[7:2], l_reg[3:2]}; bit_d = l_reg[1:0]; end
      default: addr_d = {h_reg, opnd[3:0]};
    endcase
  end

  wire legal_d = !(mode == 2'd0 && op[2]);
  wire cur     = mem_rdata[bit_q];
  wire combine = (op_q == OP_AND) || (op_q == OP_OR) || (op_q == OP_XOR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= '0; ill_q <= 1'b0; addr_q <= '0; bit_q <= '0; cy <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st <= S_RD; op_q <= op; ill_q <= !legal_d; addr_q <= addr_d; bit_q <= bit_d;
        end
        S_RD: st <= S_EX;
        default: begin
          st <= S_IDLE;
          if (!ill_q && combine)
            case (op_q)
              OP_AND:  cy <= cy & cur;
              OP_OR:   cy <= cy | cur;
              default: cy <= cy ^ cur;
            endcase
        end
      endcase
    end
  end

  assign busy      = st != S_IDLE;
  assign mem_rd    = st == S_RD;
  assign mem_addr  = addr_q;
  assign done      = st == S_EX;
  assign err       = done && ill_q;
  assign skip      = done && !ill_q && (((op_q == OP_SKT || op_q == OP_TCLR) && cur) ||
                                        (op_q == OP_SKF && !cur));
  assign mem_wr    = done && !ill_q && (op_q == OP_SET || op_q == OP_CLR || (op_q == OP_TCLR && cur));
  assign mem_wdata = (mem_rdata & ~(4'd1 << bit_q)) | ({3'd0, op_q == OP_SET} << bit_q);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R2
  rd_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> done);
  // R9
  err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n) err |-> !mem_wr && !skip);
  // R8
  cy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |=> $stable(cy));
  // R4
  one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $countones(mem_wdata ^ mem_rdata) <= 1);
  // R5
  skip_done_chk: assert property (@(posedge clk) disable iff (!rst_n) (skip || mem_wr) |-> done);
endmodule

// File: tb/bitop_unit_test.sv
module bitop_unit_test;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] op = 0;
  logic [1:0] mode = 0, bsel = 0;
  logic [7:0] opnd = 0;
  logic [3:0] h_reg = 0, l_reg = 0;
  logic busy, done, skip, err, cy, mem_rd, mem_wr;
  logic [7:0] mem_addr;
  logic [3:0] mem_wdata, mem_rdata;
  logic [3:0] mem [256];
  int checks = 0, errors = 0;
  logic cy_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitop_unit uut (.clk, .rst_n, .start, .op, .mode, .opnd, .bsel, .h_reg, .l_reg,
    .busy, .done, .skip, .err, .cy, .mem_rd, .mem_wr, .mem_addr, .mem_wdata, .mem_rdata);

  always_ff @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act=hung exp=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_addr(input logic [1:0] m, input logic [7:0] o,
                                          input logic [3:0] h, input logic [3:0] l);
    case (m)
      2'd0: return o;
      2'd1: return {2'b11, o[5:0]};
      2'd2: return {o[7:2], l[3:2]};
      default: return {h, o[3:0]};
    endcase
  endfunction

  task automatic run(input logic [2:0] o, input logic [1:0] m, input logic [7:0] f,
                     input logic [1:0] b, input logic [3:0] h, input logic [3:0] l,
                     input logic busy_poke);
    logic [7:0] a = ref_addr(m, f, h, l);
    logic [1:0] bi = (m == 2'd2) ? l[1:0] : b;
    logic [3:0] old = mem[a];
    logic bv = old[bi];
    logic ill = (m == 2'd0) && o[2];
    logic sk = !ill && (((o == 3'd2 || o == 3'd4) && bv) || (o == 3'd3 && !bv));
    logic [3:0] nw = old;
    logic ncy = cy_m;
    if (!ill) begin
      if (o == 3'd0) nw[bi] = 1'b1;
      if (o == 3'd1 || (o == 3'd4 && bv)) nw[bi] = 1'b0;
      if (o == 3'd5) ncy = cy_m & bv;
      if (o == 3'd6) ncy = cy_m | bv;
      if (o == 3'd7) ncy = cy_m ^ bv;
    end
    @(negedge clk);
    op = o; mode = m; opnd = f; bsel = b; h_reg = h; l_reg = l; start = 1;
    @(negedge clk);
    chk(mem_rd === 1'b1 && done === 1'b0, "R2 read phase", int'(mem_rd), 1);
    chk(mem_addr === a, "R3 address", int'(mem_addr), int'(a));
    if (busy_poke) begin op = 3'd0; mode = 2'd3; h_reg = ~h; end
    else start = 0;
    @(negedge clk);
    start = 0;
    chk(done === 1'b1, "R2 done", int'(done), 1);
    chk(skip === sk, "R5/R6 skip", int'(skip), int'(sk));
    chk(err === ill, "R9 err", int'(err), int'(ill));
    @(negedge clk);
    chk(done === 1'b0 && mem_rd === 1'b0, "R2/R10 single done", int'(done), 0);
    chk(mem[a] === nw, "R4/R6/R9 nibble", int'(mem[a]), int'(nw));
    chk(cy === ncy, "R7/R8 carry", int'(cy), int'(ncy));
    cy_m = ncy;
    if (busy_poke) begin
      @(negedge clk);
      chk(done === 1'b0 && busy === 1'b0, "R10 no second run", int'(done), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = 4'($urandom);
    #(CLK_PERIOD*2 + 2);
    chk(done === 0 && skip === 0 && err === 0 && busy === 0 && mem_rd === 0 &&
        mem_wr === 0 && cy === 0, "R1 reset", int'({done, skip, err, busy, cy}), 0);
    rst_n = 1;
    mem[8'h3A] = 4'b0101;
    run(3'd0, 2'd0, 8'h3A, 2'd1, 4'h0, 4'h0, 0); // R4 set middle bit
    run(3'd1, 2'd0, 8'h3A, 2'd2, 4'h0, 4'h0, 0); // R4 clear
    for (int k = 0; k < 4; k++) run(3'd0, 2'd2, 8'hA4, 2'd0, 4'h0, 4'(8 + k), 0); // R3 L-indirect
    mem[8'h5C] = 4'b0000;
    run(3'd4, 2'd3, 8'h0C, 2'd3, 4'h5, 4'h0, 0); // R6 bit 0: no clear, no skip
    mem[8'h5C] = 4'b1000;
    run(3'd4, 2'd3, 8'h0C, 2'd3, 4'h5, 4'h0, 0); // R6 bit 1: clear and skip
    run(3'd2, 2'd1, 8'h07, 2'd0, 4'h0, 4'h0, 0); // R5
    run(3'd3, 2'd1, 8'h07, 2'd0, 4'h0, 4'h0, 0); // R5
    mem[8'hC1] = 4'b0010;
    run(3'd6, 2'd1, 8'h01, 2'd1, 4'h0, 4'h0, 0); // R7 OR -> 1
    run(3'd7, 2'd0, 8'h10, 2'd0, 4'h0, 4'h0, 0); // R9 illegal XOR
    run(3'd4, 2'd0, 8'h10, 2'd0, 4'h0, 4'h0, 0); // R9 illegal test-clear
    run(3'd7, 2'd1, 8'h01, 2'd1, 4'h0, 4'h0, 0); // R7 XOR -> 0
    run(3'd1, 2'd3, 8'h02, 2'd2, 4'h9, 4'h0, 1); // R10 start held while busy
    for (int i = 0; i < 300; i++)
      run(3'($urandom), 2'($urandom), 8'($urandom), 2'($urandom), 4'($urandom), 4'($urandom),
          ($urandom % 8) == 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule